// File: doc/BRIEF.md
# Permute-Shift Address Translator

This block converts the logical coordinates of a square W×W matrix into physical addresses of a memory built from W interleaved banks, where the bank of an address is its low log2(W) bits. Every lane of a W-lane warp presents a row index and a column index. In the permute-shift mode, each row is rotated by its own offset taken from a small table. The lane's address keeps the row as its upper field, and its lower field (the bank) is the column plus the row's offset, modulo W.

The offset table has one entry per row and is filled through a write port, one entry per clock. It resets to the identity table. A flag reports whether the table currently holds a permutation of 0..W−1, meaning every offset is distinct. The rotation only guarantees conflict-free accesses when that holds. With a valid permutation, a warp that touches one whole row, or one whole column, reaches W distinct banks. A plain linear mode (address = row·W + column) is selectable per cycle, so both mappings can be compared on the same stimulus.

Top module: `permshift_xlate`

## Requirements
- R1: After synchronous active-low reset, table entry k holds k, `perm_ok` is 1 and every lane address output is 0.
- R2: When `tbl_we` is 1 at a rising clock edge, entry `tbl_idx` takes `tbl_val` at that edge. All other entries keep their values, and no entry changes while `tbl_we` is 0.
- R3: `perm_ok` is 1 exactly when the W table entries are pairwise distinct. It reflects a write from the cycle that follows the write's edge.
- R4: With `mode` = 1, lane k's address is row·W + ((col + p[row]) mod W). Here p is the table, row and col are lane k's slices `lane_row[k*LW +: LW]` and `lane_col[k*LW +: LW]`, and the address is `lane_addr[k*AW +: AW]` with the row in bits [AW-1:LW] and the bank in bits [LW-1:0].
- R5: With `mode` = 0, lane k's address is row·W + col, and the table contents have no effect on it.
- R6: With `perm_ok` = 1 and `mode` = 1, W lanes that share one row and carry W distinct columns produce W distinct banks.
- R7: With `perm_ok` = 1 and `mode` = 1, W lanes that share one column and carry W distinct rows produce W distinct banks.
- R8: With the default `REG_OUT` = 1, the addresses are registered. Inputs applied before a rising edge appear on `lane_addr` after that edge, and not before.
- R9: Each lane translates its own row and column independently of the other lanes, including when the lanes address different rows.
- R10: When the table is not a permutation, translation still applies the stored offsets unchanged. Only `perm_ok` reports the defect, and a column access may then reach fewer than W banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tbl_we | input | 1 | Write enable for the offset table |
| tbl_idx | input | LW | Table entry (row) to write |
| tbl_val | input | LW | Offset value to write |
| perm_ok | output | 1 | Table currently holds a permutation |
| mode | input | 1 | 0 = linear mapping, 1 = permute-shift mapping |
| lane_row | input | W*LW | Row index of every lane, lane k at [k*LW +: LW] |
| lane_col | input | W*LW | Column index of every lane, lane k at [k*LW +: LW] |
| lane_addr | output | W*AW | Physical address of every lane, lane k at [k*AW +: AW] |

## Verification
The bench loads a non-trivial permutation and sweeps a full row and a full column. The column sweep is the case a design with unrelated per-row offsets or a wrong table index would fail: it would map two lanes onto one bank. The full-row and full-column sweeps also catch a translator that uses the column as the table index or forgets to wrap the sum, since either error would produce wrong or colliding banks. A deliberately duplicated entry must drop `perm_ok` while translation still follows the stored offsets; a checker that only looked at the last write would miss this. A linear-mode pass after loading the table catches a mode mux that leaks the offsets, and a sample taken just before the edge catches an output stage that is missing or doubled.

// File: rtl/permshift_pkg.sv
// Package: shared mapping-mode encoding for the permute-shift translator.
// Assumes nothing beyond a 1-bit mode select at the top level.
package permshift_pkg;
    typedef enum logic {
        MAP_LINEAR  = 1'b0,
        MAP_PERMUTE = 1'b1
    } map_mode_e;
endpackage

// File: rtl/permshift_offset_table.sv
// Offset table: W entries of LW bits, written one per cycle, reset to
// the identity. Also reports whether the entries form a permutation.
// Assumes W is a power of two so that every LW-bit value is a legal row.
module permshift_offset_table #(
    parameter int W  = 8,
    parameter int LW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [LW-1:0]   wr_idx,
    input  logic [LW-1:0]   wr_val,
    output logic [W*LW-1:0] table_flat,
    output logic            perm_ok
);
    logic [LW-1:0] entry [W];
    logic [W-1:0]  seen;

    // Storage: identity on reset, single-entry write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < W; k++) entry[k] <= LW'(k);
        end else if (we) begin
            entry[wr_idx] <= wr_val;
        end
    end

    // Flatten the entries for the lanes.
    always_comb begin
        for (int k = 0; k < W; k++) table_flat[k*LW +: LW] = entry[k];
    end

    // Validity: W entries cover all W values only when they are distinct.
    always_comb begin
        seen = '0;
        for (int k = 0; k < W; k++) seen[entry[k]] = 1'b1;
        perm_ok = &seen;
    end

    // R2: a write lands in the addressed entry.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> table_flat[$past(wr_idx)*LW +: LW] == $past(wr_val));

    // R2: without a write the table holds still.
    assert_table_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> $stable(table_flat));
endmodule

// File: rtl/permshift_lane.sv
// One translation lane: combinational (row, col) -> address using the
// row's offset from the table. Modulo W is bit truncation of the sum.
// Assumes W is a power of two.
module permshift_lane
    import permshift_pkg::*;
#(
    parameter int W  = 8,
    parameter int LW = $clog2(W),
    parameter int AW = 2*LW
) (
    input  map_mode_e       mode,
    input  logic [LW-1:0]   row,
    input  logic [LW-1:0]   col,
    input  logic [W*LW-1:0] table_flat,
    output logic [AW-1:0]   addr
);
    logic [LW-1:0] offset;
    logic [LW-1:0] bank;

    // Pick this row's offset from the table.
    always_comb offset = table_flat[int'(row)*LW +: LW];

    // Rotate the column within the row, or pass it through.
    always_comb begin
        if (mode == MAP_PERMUTE) bank = col + offset;
        else                     bank = col;
        addr = {row, bank};
    end
endmodule

// File: rtl/permshift_xlate.sv
// Permute-shift address translator top: offset table, W parallel lanes
// and an optional output register (REG_OUT). Assumes W is a power of two
// and that the table is loaded with a permutation before conflict-free
// behaviour is relied on (perm_ok reports it).
module permshift_xlate
    import permshift_pkg::*;
#(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tbl_we,
    input  logic [$clog2(W)-1:0]      tbl_idx,
    input  logic [$clog2(W)-1:0]      tbl_val,
    output logic                      perm_ok,
    input  logic                      mode,
    input  logic [W*$clog2(W)-1:0]    lane_row,
    input  logic [W*$clog2(W)-1:0]    lane_col,
    output logic [W*2*$clog2(W)-1:0]  lane_addr
);
    localparam int LW = $clog2(W);
    localparam int AW = 2*LW;

    logic [W*LW-1:0] table_flat;
    logic [W*AW-1:0] addr_comb;
    map_mode_e       mode_e;

    // Convert the plain mode pin to the shared encoding.
    always_comb mode_e = map_mode_e'(mode);

    permshift_offset_table #(.W(W), .LW(LW)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (tbl_we),
        .wr_idx     (tbl_idx),
        .wr_val     (tbl_val),
        .table_flat (table_flat),
        .perm_ok    (perm_ok)
    );

    for (genvar k = 0; k < W; k++) begin : g_lane
        permshift_lane #(.W(W), .LW(LW), .AW(AW)) u_lane (
            .mode       (mode_e),
            .row        (lane_row[k*LW +: LW]),
            .col        (lane_col[k*LW +: LW]),
            .table_flat (table_flat),
            .addr       (addr_comb[k*AW +: AW])
        );

        // R4/R9: every lane keeps its own row as the upper address field.
        assert_row_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
            addr_comb[k*AW+LW +: LW] == lane_row[k*LW +: LW]);

        if (k > 0) begin : g_pair
            // R6: same row, different columns -> different banks.
            assert_row_conflict_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (mode && perm_ok && lane_row[k*LW +: LW] == lane_row[0 +: LW]
                 && lane_col[k*LW +: LW] != lane_col[0 +: LW])
                |-> addr_comb[k*AW +: LW] != addr_comb[0 +: LW]);
            // R7: same column, different rows -> different banks.
            assert_col_conflict_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (mode && perm_ok && lane_col[k*LW +: LW] == lane_col[0 +: LW]
                 && lane_row[k*LW +: LW] != lane_row[0 +: LW])
                |-> addr_comb[k*AW +: LW] != addr_comb[0 +: LW]);
        end
    end

    if (REG_OUT) begin : g_reg
        // Output stage: capture all lane addresses, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) lane_addr <= '0;
            else        lane_addr <= addr_comb;
        end
        // R5: in linear mode the registered address is the raw (row, col).
        assert_linear_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !mode |=> lane_addr[AW-1:0] == {$past(lane_row[LW-1:0]), $past(lane_col[LW-1:0])});
    end else begin : g_comb
        // Output stage bypassed: addresses follow the inputs directly.
        always_comb lane_addr = addr_comb;
    end
endmodule

// File: tb/test_permshift_xlate.sv
`timescale 1ns/100ps
module test_permshift_xlate;
    localparam int W  = 8;
    localparam int LW = $clog2(W);
    localparam int AW = 2*LW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tbl_we = 1'b0;
    logic [LW-1:0]   tbl_idx = '0;
    logic [LW-1:0]   tbl_val = '0;
    logic            perm_ok;
    logic            mode = 1'b0;
    logic [W*LW-1:0] lane_row = '0;
    logic [W*LW-1:0] lane_col = '0;
    logic [W*AW-1:0] lane_addr;

    int checks = 0;
    int errors = 0;
    int p_model [W];

    permshift_xlate #(.W(W), .REG_OUT(1'b1)) i_permshift_xlate (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_val(tbl_val), .perm_ok(perm_ok), .mode(mode),
        .lane_row(lane_row), .lane_col(lane_col), .lane_addr(lane_addr)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete (got timeout, expected finish)");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int model_addr(input int r, input int c, input bit m);
        return m ? r*W + ((c + p_model[r]) % W) : r*W + c;
    endfunction

    // Drive lanes at a falling edge, sample after the next rising edge.
    task automatic apply(input int rows [W], input int cols [W], input bit m);
        @(negedge clk);
        mode = m;
        for (int k = 0; k < W; k++) begin
            lane_row[k*LW +: LW] = LW'(rows[k]);
            lane_col[k*LW +: LW] = LW'(cols[k]);
        end
        @(negedge clk);
    endtask

    task automatic check_lanes(input string req, input int rows [W], input int cols [W], input bit m);
        for (int k = 0; k < W; k++)
            check(req, int'(lane_addr[k*AW +: AW]), model_addr(rows[k], cols[k], m));
    endtask

    function automatic int bank_count();
        logic [W-1:0] seen = '0;
        for (int k = 0; k < W; k++) seen[lane_addr[k*AW +: LW]] = 1'b1;
        return $countones(seen);
    endfunction

    task automatic write_entry(input int idx, input int val);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = LW'(idx); tbl_val = LW'(val);
        @(negedge clk);
        tbl_we = 1'b0;
        p_model[idx] = val;
    endtask

    task automatic test_reset();
        check("R1 perm_ok", int'(perm_ok), 1);
        check("R1 addr", int'(lane_addr), 0);
        for (int k = 0; k < W; k++) p_model[k] = k;
    endtask

    task automatic test_identity_table();
        int rows [W]; int cols [W];
        for (int k = 0; k < W; k++) begin rows[k] = k; cols[k] = 3; end
        apply(rows, cols, 1'b1);
        check_lanes("R1 identity offsets", rows, cols, 1'b1);
    endtask

    task automatic test_load_perm();
        int perm [W] = '{5, 2, 7, 0, 3, 6, 1, 4};
        for (int k = 0; k < W; k++) write_entry(k, perm[k]);
        check("R3 perm_ok after load", int'(perm_ok), 1);
    endtask

    task automatic test_row_sweep();
        int rows [W]; int cols [W];
        for (int k = 0; k < W; k++) begin rows[k] = 2; cols[k] = k; end
        apply(rows, cols, 1'b1);
        check_lanes("R4 row sweep", rows, cols, 1'b1);
        check("R6 row banks", bank_count(), W);
    endtask

    task automatic test_col_sweep();
        int rows [W]; int cols [W];
        for (int k = 0; k < W; k++) begin rows[k] = W-1-k; cols[k] = 5; end
        apply(rows, cols, 1'b1);
        check_lanes("R4 column sweep", rows, cols, 1'b1);
        check("R7 column banks", bank_count(), W);
    endtask

    task automatic test_linear();
        int rows [W]; int cols [W];
        for (int k = 0; k < W; k++) begin rows[k] = k; cols[k] = (3*k+1) % W; end
        apply(rows, cols, 1'b0);
        check_lanes("R5 linear ignores table", rows, cols, 1'b0);
        for (int k = 0; k < W; k++) begin rows[k] = 4; cols[k] = 4; end
        apply(rows, cols, 1'b0);
        check("R5 linear column-heavy", int'(lane_addr[AW-1:0]), 4*W+4);
    endtask

    task automatic test_mixed();
        int rows [W]; int cols [W];
        for (int k = 0; k < W; k++) begin rows[k] = (5*k+3) % W; cols[k] = (7*k+2) % W; end
        apply(rows, cols, 1'b1);
        check_lanes("R9 mixed lanes", rows, cols, 1'b1);
    endtask

    task automatic test_latency();
        int rows [W]; int cols [W];
        int before_val;
        for (int k = 0; k < W; k++) begin rows[k] = 6; cols[k] = W-1; end
        apply(rows, cols, 1'b1);
        before_val = int'(lane_addr[AW-1:0]);
        @(negedge clk);
        lane_row[LW-1:0] = LW'(1); lane_col[LW-1:0] = LW'(0);
        #1;
        check("R8 no change before edge", int'(lane_addr[AW-1:0]), before_val);
        @(negedge clk);
        check("R8 change after edge", int'(lane_addr[AW-1:0]), model_addr(1, 0, 1'b1));
    endtask

    task automatic test_invalid();
        int rows [W]; int cols [W];
        int saved = p_model[1];
        write_entry(1, p_model[0]);
        check("R3 duplicate clears perm_ok", int'(perm_ok), 0);
        for (int k = 0; k < W; k++) begin rows[k] = k; cols[k] = 0; end
        apply(rows, cols, 1'b1);
        check_lanes("R10 stored offsets used", rows, cols, 1'b1);
        check("R10 column collides", bank_count(), W-1);
        write_entry(1, saved);
        check("R3 restore sets perm_ok", int'(perm_ok), 1);
        check("R2 other entries intact", int'(lane_addr[AW-1:0]), model_addr(0, 0, 1'b1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_identity_table();
        test_load_perm();
        test_row_sweep();
        test_col_sweep();
        test_linear();
        test_mixed();
        test_latency();
        test_invalid();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule